// File: doc/BRIEF.md
# Dual-Width Transmit/Receive FIFO Port

This block holds a transmit FIFO and a receive FIFO between a 32-bit register bus and a byte-serial engine. Software may move data one byte per access or four bytes per access; word accesses are packed and unpacked with the least significant byte first, so byte 0 of a word travels first on the serial side. The engine pops transmit bytes and pushes receive bytes one at a time.

A mode bit chooses whether the full, empty and available flags are reported per byte or per four-byte word. A status word collects two sticky completion events raised by the engine, the live FIFO flags, an engine-idle indication and the mode bit. An enable mask selects which of the six low status bits drive the interrupt line.

Register select on `bus_addr`: 0 control (bit 0 = word-flag mode), 1 status, 2 interrupt enable (bits 5:0), 3 transmit byte, 4 receive byte, 5 transmit word, 6 receive word. Read data is combinational; a read of a data select pops in the clock edge that ends the access, and a write commits in that edge.

Top module: `dfp_top`

## Requirements
- R1: Bytes written to select 3 (only bits 7:0 used) appear on `tx_data` in write order, and bytes pushed by the engine are read from select 4 in push order, in bits 7:0 with the upper bits zero.
- R2: A write to select 5 queues four bytes, bits 7:0 first; a read of select 6 pops four bytes and returns the oldest in bits 7:0 and the fourth in bits 31:24.
- R3: With control bit 0 clear, the transmit full flag (status bit 5) is set exactly when DEPTH bytes are held and the receive empty flag (status bit 4) exactly when none are held.
- R4: With control bit 0 set, status bit 5 is set when fewer than four free transmit bytes remain, status bit 4 is set when fewer than four receive bytes are held, and status bit 8 reads 1.
- R5: A byte write with no free byte, or a word write with fewer than four free bytes, changes nothing in the transmit FIFO.
- R6: A byte read with no byte held, or a word read with fewer than four bytes held, returns zero and pops nothing.
- R7: Status bit 2 is the inverse of bit 4 and status bit 3 the inverse of bit 5; bit 6 and bits above 8 read zero.
- R8: A pulse on `tx_done_evt` sets status bit 0 and on `rx_done_evt` sets bit 1; each stays set until a status write with a 1 in its position, and a 0 there leaves it unchanged. An event in the same cycle as the clear wins.
- R9: `irq` is high exactly when some bit of status 5:0 and the same bit of the enable register are both 1.
- R10: After reset both FIFOs are empty, control and enable read zero, events are clear and `irq` is low.
- R11: Status bit 7 follows `eng_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| rx_push | input | 1 | Engine offers one receive byte |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive FIFO has a free byte |
| tx_done_evt | input | 1 | Transmit completion pulse |
| rx_done_evt | input | 1 | Receive completion pulse |
| eng_idle | input | 1 | Engine idle indication |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count shows at the ports on the next access: a byte out of order on `tx_data` or in a read, a stale or missing byte after a drain, or a flag in the status word that disagrees with the number of bytes moved so far. A wrong event or enable bit shows as a status read or an `irq` level that differs in the cycle after the pulse or clear. Filling each FIFO to its limit in both flag modes and then draining it exposes an accepted overflow or a pop of an empty FIFO within one drain.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_STAT  = 3'd1;
    localparam logic [2:0] SEL_IEN   = 3'd2;
    localparam logic [2:0] SEL_TXB   = 3'd3;
    localparam logic [2:0] SEL_RXB   = 3'd4;
    localparam logic [2:0] SEL_TXW   = 3'd5;
    localparam logic [2:0] SEL_RXW   = 3'd6;

    localparam int ST_TXDONE = 0;
    localparam int ST_RXDONE = 1;
    localparam int ST_RXAV   = 2;
    localparam int ST_TXAV   = 3;
    localparam int ST_RXEMP  = 4;
    localparam int ST_TXFULL = 5;
    localparam int ST_IDLE   = 7;
    localparam int ST_WORD   = 8;
    localparam int STAT_W    = 9;
    localparam int EVT_W     = 6;
endpackage

// File: rtl/dfp_fifo.sv
module dfp_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    wr_n,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_n,
    output logic [31:0]   head,
    output logic [CW-1:0] count
);
    localparam logic [AW:0] DEPTH_X = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t       p_d, p_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] wrap(input logic [AW:0] v);
        return (v >= DEPTH_X) ? AW'(v - DEPTH_X) : AW'(v);
    endfunction

    always_comb begin
        p_d   = p_q;
        mem_d = mem_q;
        for (int i = 0; i < 4; i++) begin
            if (i < int'(wr_n)) begin
                mem_d[wrap({1'b0, p_q.wp} + (AW + 1)'(i))] = wr_data[8*i +: 8];
            end
        end
        p_d.wp  = wrap({1'b0, p_q.wp} + (AW + 1)'(wr_n));
        p_d.rp  = wrap({1'b0, p_q.rp} + (AW + 1)'(rd_n));
        p_d.cnt = p_q.cnt + CW'(wr_n) - CW'(rd_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar g = 0; g < 4; g++) begin : g_head
        assign head[8*g +: 8] = mem_q[wrap({1'b0, p_q.rp} + (AW + 1)'(g))];
    end

    assign count = p_q.cnt;
endmodule

// File: rtl/dfp_regs.sv
module dfp_regs
    import dfp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_stat,
    input  logic                wr_ien,
    input  logic [5:0]          wdata,
    input  logic [CW-1:0]       tx_cnt,
    input  logic [CW-1:0]       rx_cnt,
    input  logic                tx_done_evt,
    input  logic                rx_done_evt,
    input  logic                eng_idle,
    output logic                word_mode,
    output logic [EVT_W-1:0]    ien,
    output logic [STAT_W-1:0]   status,
    output logic                irq
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] FOUR = CW'(4);

    typedef struct packed {
        logic             word;
        logic [1:0]       ev;
        logic [EVT_W-1:0] en;
    } reg_t;

    reg_t r_d, r_q;
    logic tx_full, rx_empty;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.word = wdata[0];
        if (wr_ien)  r_d.en   = wdata;
        if (wr_stat) r_d.ev   = r_q.ev & ~wdata[1:0];
        if (tx_done_evt) r_d.ev[0] = 1'b1;
        if (rx_done_evt) r_d.ev[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.word) begin
            tx_full  = (FULL - tx_cnt) < FOUR;
            rx_empty = rx_cnt < FOUR;
        end else begin
            tx_full  = tx_cnt == FULL;
            rx_empty = rx_cnt == '0;
        end
        status            = '0;
        status[ST_TXDONE] = r_q.ev[0];
        status[ST_RXDONE] = r_q.ev[1];
        status[ST_RXAV]   = !rx_empty;
        status[ST_TXAV]   = !tx_full;
        status[ST_RXEMP]  = rx_empty;
        status[ST_TXFULL] = tx_full;
        status[ST_IDLE]   = eng_idle;
        status[ST_WORD]   = r_q.word;
    end

    assign irq       = |(status[EVT_W-1:0] & r_q.en);
    assign word_mode = r_q.word;
    assign ien       = r_q.en;
endmodule

// File: rtl/dfp_top.sv
module dfp_top
    import dfp_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    input  logic        tx_done_evt,
    input  logic        rx_done_evt,
    input  logic        eng_idle,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] FOUR = CW'(4);

    logic [CW-1:0]     tx_count, rx_count;
    logic [31:0]       tx_head, rx_head;
    logic [2:0]        tx_wr_n, tx_rd_n, rx_wr_n, rx_rd_n;
    logic [31:0]       tx_wr_data;
    logic              word_mode;
    logic [EVT_W-1:0]  ien;
    logic [STAT_W-1:0] stat_w;
    logic [CW-1:0]     tx_free;

    assign tx_free = FULL - tx_count;

    always_comb begin
        tx_wr_n    = 3'd0;
        tx_wr_data = bus_wdata;
        if (bus_wr && bus_addr == SEL_TXB && tx_free != '0) begin
            tx_wr_n    = 3'd1;
            tx_wr_data = {24'd0, bus_wdata[7:0]};
        end else if (bus_wr && bus_addr == SEL_TXW && tx_free >= FOUR) begin
            tx_wr_n = 3'd4;
        end
        tx_rd_n = (tx_pop && tx_count != '0) ? 3'd1 : 3'd0;
        rx_wr_n = (rx_push && rx_count != FULL) ? 3'd1 : 3'd0;
        rx_rd_n = 3'd0;
        if (bus_rd && bus_addr == SEL_RXB && rx_count != '0) begin
            rx_rd_n = 3'd1;
        end else if (bus_rd && bus_addr == SEL_RXW && rx_count >= FOUR) begin
            rx_rd_n = 3'd4;
        end
    end

    dfp_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .wr_n(tx_wr_n), .wr_data(tx_wr_data),
        .rd_n(tx_rd_n), .head(tx_head), .count(tx_count)
    );

    dfp_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .wr_n(rx_wr_n), .wr_data({24'd0, rx_data}),
        .rd_n(rx_rd_n), .head(rx_head), .count(rx_count)
    );

    dfp_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(bus_wr && bus_addr == SEL_CTRL),
        .wr_stat(bus_wr && bus_addr == SEL_STAT),
        .wr_ien(bus_wr && bus_addr == SEL_IEN),
        .wdata(bus_wdata[5:0]),
        .tx_cnt(tx_count), .rx_cnt(rx_count),
        .tx_done_evt(tx_done_evt), .rx_done_evt(rx_done_evt),
        .eng_idle(eng_idle),
        .word_mode(word_mode), .ien(ien), .status(stat_w), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            SEL_CTRL: bus_rdata = {31'd0, word_mode};
            SEL_STAT: bus_rdata = {{(32 - STAT_W){1'b0}}, stat_w};
            SEL_IEN:  bus_rdata = {{(32 - EVT_W){1'b0}}, ien};
            SEL_RXB:  bus_rdata = (rx_count != '0) ? {24'd0, rx_head[7:0]} : 32'd0;
            SEL_RXW:  bus_rdata = (rx_count >= FOUR) ? rx_head : 32'd0;
            default:  bus_rdata = '0;
        endcase
    end

    assign tx_valid = tx_count != '0;
    assign tx_data  = tx_valid ? tx_head[7:0] : 8'd0;
    assign rx_ready = rx_count != FULL;
endmodule

// File: rtl/dfp_checker.sv
module dfp_checker
    import dfp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              tx_pop,
    input logic              tx_done_evt,
    input logic              rx_done_evt,
    input logic [CW-1:0]     tx_count,
    input logic [CW-1:0]     rx_count,
    input logic [STAT_W-1:0] stat_w
);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SEL_RXB && rx_count == '0) |-> (bus_rdata == 32'd0));

    assert_pop_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_count != '0 && !(bus_wr && (bus_addr == SEL_TXB || bus_addr == SEL_TXW)))
        |=> (tx_count == $past(tx_count) - CW'(1)));

    assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_evt |=> stat_w[ST_TXDONE]);

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_STAT && bus_wdata[ST_RXDONE] && !rx_done_evt)
        |=> !stat_w[ST_RXDONE]);
endmodule

bind dfp_top dfp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pop(tx_pop), .tx_done_evt(tx_done_evt), .rx_done_evt(rx_done_evt),
    .tx_count(tx_count), .rx_count(rx_count), .stat_w(stat_w)
);

// File: tb/dfp_top_test.sv
module dfp_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_POP = 2'd2, OP_PUSH = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  sel;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,   3'd1, 32'h0,        32'h98,       4'd10}, // R10 reset status
        '{OP_RD,   3'd2, 32'h0,        32'h0,        4'd10}, // R10 enable zero
        '{OP_WR,   3'd3, 32'h1A5,      32'h0,        4'd1},  // R1
        '{OP_WR,   3'd3, 32'h3C,       32'h0,        4'd1},
        '{OP_POP,  3'd0, 32'h0,        32'hA5,       4'd1},
        '{OP_POP,  3'd0, 32'h0,        32'h3C,       4'd1},
        '{OP_WR,   3'd5, 32'h44332211, 32'h0,        4'd2},  // R2 packing
        '{OP_POP,  3'd0, 32'h0,        32'h11,       4'd2},
        '{OP_POP,  3'd0, 32'h0,        32'h22,       4'd2},
        '{OP_POP,  3'd0, 32'h0,        32'h33,       4'd2},
        '{OP_POP,  3'd0, 32'h0,        32'h44,       4'd2},
        '{OP_PUSH, 3'd0, 32'h5A,       32'h0,        4'd1},
        '{OP_PUSH, 3'd0, 32'h6B,       32'h0,        4'd1},
        '{OP_RD,   3'd4, 32'h0,        32'h5A,       4'd1},
        '{OP_RD,   3'd4, 32'h0,        32'h6B,       4'd1},
        '{OP_PUSH, 3'd0, 32'h01,       32'h0,        4'd2},
        '{OP_PUSH, 3'd0, 32'h02,       32'h0,        4'd2},
        '{OP_PUSH, 3'd0, 32'h03,       32'h0,        4'd2},
        '{OP_RD,   3'd6, 32'h0,        32'h0,        4'd6},  // R6 word read of 3 bytes
        '{OP_PUSH, 3'd0, 32'h04,       32'h0,        4'd2},
        '{OP_RD,   3'd6, 32'h0,        32'h04030201, 4'd2},  // R2 unpacking
        '{OP_RD,   3'd4, 32'h0,        32'h0,        4'd6}   // R6 empty byte read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_done_evt = 1'b0, rx_done_evt = 1'b0;
    logic        eng_idle = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] got;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dfp_top #(.DEPTH(DEPTH)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic pop(output logic [31:0] v);
        @(negedge clk);
        tx_pop = 1'b1;
        #1 v = {23'd0, tx_valid, tx_data};
        @(posedge clk); #1 tx_pop = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d;
        @(posedge clk); #1 rx_push = 1'b0;
    endtask

    task automatic pulse_tx_done();
        @(negedge clk);
        tx_done_evt = 1'b1;
        @(posedge clk); #1 tx_done_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R10 irq", {31'd0, irq}, 32'd0);
        check("R10 tx_valid", {31'd0, tx_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (VECS[i].op)
                OP_WR:   bw(VECS[i].sel, VECS[i].data);
                OP_RD:   begin br(VECS[i].sel, got); check(tag, got, VECS[i].exp); end
                OP_POP:  begin pop(got); check(tag, got, VECS[i].exp | 32'h100); end
                default: push(VECS[i].data[7:0]);
            endcase
        end

        // R3 byte-mode full, R5 overflow ignored
        for (int i = 0; i < DEPTH; i++) bw(3'd3, 32'h40 + i);
        br(3'd1, got); check("R3 full status", got, 32'hB0);
        bw(3'd3, 32'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            pop(got); check("R3 drain", got, 32'h100 | (32'h40 + i));
        end
        #1 check("R5 nothing extra", {31'd0, tx_valid}, 32'd0);
        br(3'd1, got); check("R3 R7 empty status", got, 32'h98);

        // R4 word-flag mode
        bw(3'd0, 32'h1);
        for (int i = 0; i < DEPTH - 3; i++) bw(3'd3, 32'h1 + i);
        push(8'h01); push(8'h02); push(8'h03);
        br(3'd1, got); check("R4 word flags", got, 32'h1B0);
        bw(3'd5, 32'hDEADBEEF);
        for (int i = 0; i < DEPTH - 3; i++) begin
            pop(got); check("R4 drain", got, 32'h100 | (32'h1 + i));
        end
        #1 check("R5 word write ignored", {31'd0, tx_valid}, 32'd0);
        push(8'h04);
        br(3'd1, got); check("R4 R7 rx available", got, 32'h18C);
        br(3'd6, got); check("R4 word read", got, 32'h04030201);
        br(3'd0, got); check("R4 ctrl readback", got, 32'h1);
        bw(3'd0, 32'h0);

        // R8 sticky events, R9 interrupt
        bw(3'd2, 32'h01);
        br(3'd2, got); check("R9 enable readback", got, 32'h01);
        #1 check("R9 irq masked", {31'd0, irq}, 32'd0);
        pulse_tx_done();
        br(3'd1, got); check("R8 event set", got, 32'h99);
        check("R9 irq on event", {31'd0, irq}, 32'd1);
        bw(3'd1, 32'h2);
        br(3'd1, got); check("R8 zero keeps", got, 32'h99);
        bw(3'd1, 32'h1);
        br(3'd1, got); check("R8 one clears", got, 32'h98);
        check("R9 irq drops", {31'd0, irq}, 32'd0);
        bw(3'd2, 32'h10);
        #1 check("R9 irq on rx empty", {31'd0, irq}, 32'd1);
        bw(3'd2, 32'h0);

        // R11 idle mirror
        eng_idle = 1'b0;
        br(3'd1, got); check("R11 idle low", got, 32'h18);
        eng_idle = 1'b1;

        finish_run();
    end
endmodule